// File: doc/BRIEF.md
# Serial Controller Register Front End

This block is the register and interrupt side of a simple byte-oriented serial controller. It sits on a 32-bit, byte-addressable bus and decodes a 256-byte window. Software uses it to set the line, baud and FIFO configuration and to enable interrupts. It also pushes characters for transmission and pops received characters. Bit serialization and baud timing live elsewhere. Here the serial side is a byte stream. Transmit bytes leave through a valid/ready output, where a byte is handed over in any cycle with both `tx_valid` and `tx_ready` high. While `tx_ready` is low, `tx_valid` and `tx_data` hold. Received bytes arrive on a valid-only input with no back-pressure. A byte offered while the receive FIFO is full is lost.

Each stored register applies its own write mask after a byte-lane merge. Two status flags are set by hardware from the FIFO state and stay set until software clears them. A single level interrupt is raised while any enabled status flag is set. Both FIFOs can be flushed by software. A flush takes a dedicated enable bit together with the per-FIFO flush bit.

Top module: `serial_reg_front`

## Requirements
- R1: After reset, line control reads 0x40000000 and baud-rate reads 0x03FF0000. Line status, interrupt enable and FIFO control read 0. Interrupt status reads 0x00020000, because the empty transmit FIFO sets bit 17 on the first clock after reset. Both FIFOs are empty, `tx_valid` is low and `irq` is low.
- R2: Byte lanes are big-endian. Enable `be[3]` selects bits 31:24, which is the byte at the lowest address of the word. Enable `be[0]` selects bits 7:0. Each enabled lane is written independently and disabled lanes keep their old value. Address bits 1:0 are ignored.
- R3: The masks applied after each write are as follows. Line control (0x00) keeps 0xE17F0000. Interrupt enable (0x08) keeps 0x000F0000. Interrupt status (0x0C) keeps 0x00070000. FIFO control (0x10) keeps 0x001F0000. Baud-rate (0x14) keeps 0x03FF0000. Line status (0x04) is read-only and reads 0.
- R4: Any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x20 and 0x30 reads 0, and writes to it change nothing.
- R5: A request with `req` high is taken at a clock edge. A read returns `rdata` with `rvalid` high in the following cycle. `rvalid` is low after a write or idle cycle. A write takes effect at that same edge.
- R6: A write to 0x20 with `be[3]` set pushes `wdata[31:24]` into the transmit FIFO (8 entries) unless it is full. Writes that do not enable `be[3]`, and writes while the FIFO is full, are ignored. Reads of 0x20 return 0.
- R7: `tx_valid` is high while the transmit FIFO holds data, and `tx_data` is its oldest byte. A byte is removed on each cycle with `tx_valid` and `tx_ready` both high, and bytes leave in push order.
- R8: Each cycle with `rx_valid` high pushes `rx_data` into the receive FIFO (8 entries). A byte that arrives while the FIFO is full is dropped.
- R9: A read of 0x30 with `be[3]` set pops the oldest received byte and returns it in bits 31:24, with the other bits 0. If the FIFO is empty it returns 0 and pops nothing. A read of 0x30 without `be[3]` returns 0 and pops nothing. Writes to 0x30 are ignored.
- R10: Interrupt status bit 16 is set while the receive FIFO is not empty, and bit 17 is set while the transmit FIFO is empty. Set flags stay set. A software write clears a flag only if its set condition is absent in that cycle.
- R11: `irq` is high exactly when the interrupt status and interrupt enable registers share a set bit. It follows register updates in the same cycle.
- R12: A write to FIFO control whose resulting value has bit 16 and bit 17 set empties the receive FIFO. A resulting value with bit 16 and bit 18 set empties the transmit FIFO. Without bit 16, neither flush happens.
- R13: Interrupt enable bit 19 is stored and read back but has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset within the window |
| be | input | 4 | Byte-lane enables, be[3] = bits 31:24 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| rvalid | output | 1 | High in the cycle carrying read data |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Consumer takes tx_data this cycle |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |

## Verification
The bench builds the block with the default FIFO depth of 8. This lets both FIFOs be driven to full in a handful of cycles. A ninth byte can therefore be offered to each, and the bench checks that it is dropped without disturbing the order of the first eight. The short depth also keeps every receive pop and transmit drain within directed sequences whose expected byte values are computed directly in the bench.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int WORD_W = 6;

  localparam logic [WORD_W-1:0] WI_LCR = 6'd0;
  localparam logic [WORD_W-1:0] WI_LSR = 6'd1;
  localparam logic [WORD_W-1:0] WI_IER = 6'd2;
  localparam logic [WORD_W-1:0] WI_ISR = 6'd3;
  localparam logic [WORD_W-1:0] WI_FCR = 6'd4;
  localparam logic [WORD_W-1:0] WI_BRR = 6'd5;
  localparam logic [WORD_W-1:0] WI_TXF = 6'd8;
  localparam logic [WORD_W-1:0] WI_RXF = 6'd12;

  localparam logic [BUS_W-1:0] LCR_MASK = 32'hE17F_0000;
  localparam logic [BUS_W-1:0] IER_MASK = 32'h000F_0000;
  localparam logic [BUS_W-1:0] ISR_MASK = 32'h0007_0000;
  localparam logic [BUS_W-1:0] FCR_MASK = 32'h001F_0000;
  localparam logic [BUS_W-1:0] BRR_MASK = 32'h03FF_0000;

  localparam logic [BUS_W-1:0] LCR_INIT = 32'h4000_0000;
  localparam logic [BUS_W-1:0] BRR_INIT = 32'h03FF_0000;
  localparam logic [BUS_W-1:0] LSR_VAL  = 32'h0000_0000;

  localparam int ST_RX_BIT  = 16;
  localparam int ST_TX_BIT  = 17;
  localparam int FC_EN_BIT  = 16;
  localparam int FC_RX_BIT  = 17;
  localparam int FC_TX_BIT  = 18;

  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [LANES-1:0] en);
    logic [BUS_W-1:0] r;
    r = old_v;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/csr_lane_reg.sv
module csr_lane_reg
  import serial_reg_pkg::*;
#(
  parameter logic [BUS_W-1:0] MASK = '1,
  parameter logic [BUS_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LANES-1:0] be,
  input  logic [BUS_W-1:0] wdata,
  input  logic [BUS_W-1:0] set_bits,
  output logic [BUS_W-1:0] wval,
  output logic [BUS_W-1:0] q
);
  assign wval = MASK & lane_merge(q, wdata, be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= INIT;
    else        q <= ((wr ? wval : q) | set_bits) & MASK;
  end
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import serial_reg_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [7:0]       addr,
  input  logic [LANES-1:0] be,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             rvalid,
  output logic             irq,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data
);
  logic [WORD_W-1:0] word;
  logic              wr, rd, unused_addr;
  logic [BUS_W-1:0]  lcr_q, ier_q, isr_q, fcr_q, brr_q;
  logic [BUS_W-1:0]  lcr_w, ier_w, isr_w, fcr_w, brr_w;
  logic [BUS_W-1:0]  isr_set;
  logic              tx_push, tx_pop, tx_flush, tx_empty;
  logic              rx_pop, rx_flush, rx_empty;
  logic [7:0]        rx_head;
  logic [CW-1:0]     tx_count, rx_count;
  logic [BUS_W-1:0]  rd_mux;

  assign word        = addr[7:2];
  assign unused_addr = ^addr[1:0];
  assign wr          = req && we;
  assign rd          = req && !we;

  csr_lane_reg #(.MASK(LCR_MASK), .INIT(LCR_INIT)) u_lcr (
    .clk(clk), .rst_n(rst_n), .wr(wr && word == WI_LCR), .be(be), .wdata(wdata),
    .set_bits('0), .wval(lcr_w), .q(lcr_q));
  csr_lane_reg #(.MASK(IER_MASK), .INIT('0)) u_ier (
    .clk(clk), .rst_n(rst_n), .wr(wr && word == WI_IER), .be(be), .wdata(wdata),
    .set_bits('0), .wval(ier_w), .q(ier_q));
  csr_lane_reg #(.MASK(ISR_MASK), .INIT('0)) u_isr (
    .clk(clk), .rst_n(rst_n), .wr(wr && word == WI_ISR), .be(be), .wdata(wdata),
    .set_bits(isr_set), .wval(isr_w), .q(isr_q));
  csr_lane_reg #(.MASK(FCR_MASK), .INIT('0)) u_fcr (
    .clk(clk), .rst_n(rst_n), .wr(wr && word == WI_FCR), .be(be), .wdata(wdata),
    .set_bits('0), .wval(fcr_w), .q(fcr_q));
  csr_lane_reg #(.MASK(BRR_MASK), .INIT(BRR_INIT)) u_brr (
    .clk(clk), .rst_n(rst_n), .wr(wr && word == WI_BRR), .be(be), .wdata(wdata),
    .set_bits('0), .wval(brr_w), .q(brr_q));

  logic unused_wvals;
  assign unused_wvals = ^{lcr_w, ier_w, isr_w, brr_w};

  always_comb begin
    isr_set = '0;
    isr_set[ST_RX_BIT] = !rx_empty;
    isr_set[ST_TX_BIT] = tx_empty;
  end

  assign rx_flush = wr && word == WI_FCR && fcr_w[FC_EN_BIT] && fcr_w[FC_RX_BIT];
  assign tx_flush = wr && word == WI_FCR && fcr_w[FC_EN_BIT] && fcr_w[FC_TX_BIT];
  assign tx_push  = wr && word == WI_TXF && be[LANES-1];
  assign rx_pop   = rd && word == WI_RXF && be[LANES-1];
  assign tx_pop   = tx_valid && tx_ready;

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
    .din(wdata[BUS_W-1 -: 8]), .pop(tx_pop), .dout(tx_data),
    .empty(tx_empty), .count(tx_count));

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_valid),
    .din(rx_data), .pop(rx_pop), .dout(rx_head),
    .empty(rx_empty), .count(rx_count));

  assign tx_valid = !tx_empty;
  assign irq      = |(isr_q & ier_q);

  always_comb begin
    case (word)
      WI_LCR:  rd_mux = lcr_q;
      WI_LSR:  rd_mux = LSR_VAL;
      WI_IER:  rd_mux = ier_q;
      WI_ISR:  rd_mux = isr_q;
      WI_FCR:  rd_mux = fcr_q;
      WI_BRR:  rd_mux = brr_q;
      WI_RXF:  rd_mux = (be[LANES-1] && !rx_empty) ? {rx_head, 24'h0} : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/serial_reg_front_chk.sv
module serial_reg_front_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [5:0]    word,
  input logic [31:0]   rdata,
  input logic          rvalid,
  input logic          irq,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_ready,
  input logic          tx_flush,
  input logic [31:0]   ier_q,
  input logic [31:0]   isr_q,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid); // R5
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || we) |=> !rvalid); // R5
  AST_LSR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && word == 6'd1) |=> (rdata == 32'h0)); // R3
  AST_TXF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && word == 6'd8) |=> (rdata == 32'h0)); // R6
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && word == 6'd12 && rx_count == '0) |=> (rdata == 32'h0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH))); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_flush) |=> (tx_valid && $stable(tx_data))); // R7
  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q[16] && !(req && we && word == 6'd3)) |=> isr_q[16]); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 32'h0) |-> !irq); // R11
endmodule

bind serial_reg_front serial_reg_front_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .word(addr[7:2]),
  .rdata(rdata), .rvalid(rvalid), .irq(irq), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .tx_flush(tx_flush),
  .ier_q(ier_q), .isr_q(isr_q), .rx_count(rx_count), .tx_count(tx_count));

// File: tb/serial_reg_front_tb.sv
`timescale 1ns/1ps
module serial_reg_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;
  int vec = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_reg_front u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; be = b;
    @(negedge clk);
    req = 0;
    chk("R5 rvalid", {31'h0, rvalid}, 32'h1);
    d = rdata;
  endtask

  task automatic rx_feed(input logic [7:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = first + 8'(i);
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, 4'hF, d); chk("R1 line ctrl", d, 32'h4000_0000);
    rd(8'h14, 4'hF, d); chk("R1 baud", d, 32'h03FF_0000);
    rd(8'h04, 4'hF, d); chk("R1 line status", d, 0);
    rd(8'h08, 4'hF, d); chk("R1 int enable", d, 0);
    rd(8'h10, 4'hF, d); chk("R1 fifo ctrl", d, 0);
    rd(8'h0C, 4'hF, d); chk("R1 int status", d, 32'h0002_0000);
    chk("R1 tx_valid", {31'h0, tx_valid}, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    rd(8'h30, 4'h8, d); chk("R1 rx empty", d, 0);
  endtask

  task automatic t_lanes_masks();
    logic [31:0] d;
    wr(8'h00, 4'b1000, 32'hFFFF_FFFF);
    rd(8'h00, 4'hF, d); chk("R2 top lane", d, 32'hE100_0000);
    wr(8'h01, 4'b0100, 32'h00FF_0000);
    rd(8'h00, 4'hF, d); chk("R2 lane 2", d, 32'hE17F_0000);
    wr(8'h00, 4'b0011, 32'hFFFF_FFFF);
    rd(8'h00, 4'hF, d); chk("R3 lcr low lanes masked", d, 32'hE17F_0000);
    wr(8'h00, 4'hF, 32'h0);
    rd(8'h00, 4'hF, d); chk("R2 full clear", d, 0);
    wr(8'h14, 4'hF, 32'hFFFF_FFFF);
    rd(8'h14, 4'hF, d); chk("R3 baud mask", d, 32'h03FF_0000);
    wr(8'h04, 4'hF, 32'hFFFF_FFFF);
    rd(8'h04, 4'hF, d); chk("R3 line status ro", d, 0);
    wr(8'h08, 4'hF, 32'hFFFF_FFFF);
    rd(8'h08, 4'hF, d); chk("R3 ier mask", d, 32'h000F_0000);
    chk("R11 irq on", {31'h0, irq}, 1);
    wr(8'h08, 4'hF, 32'h0);
    chk("R11 irq off", {31'h0, irq}, 0);
    wr(8'h0C, 4'hF, 32'hFFFF_FFFF);
    rd(8'h0C, 4'hF, d); chk("R3 isr mask", d, 32'h0007_0000);
    wr(8'h0C, 4'hF, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h18, 4'hF, 32'hFFFF_FFFF);
    wr(8'h24, 4'hF, 32'hFFFF_FFFF);
    rd(8'h18, 4'hF, d); chk("R4 0x18", d, 0);
    rd(8'h24, 4'hF, d); chk("R4 0x24", d, 0);
    rd(8'hFC, 4'hF, d); chk("R4 0xFC", d, 0);
    rd(8'h00, 4'hF, d); chk("R4 lcr intact", d, 0);
    rd(8'h08, 4'hF, d); chk("R4 ier intact", d, 0);
    chk("R4 no tx push", {31'h0, tx_valid}, 0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    logic [7:0] got [$];
    logic [7:0] exp [$];
    tx_ready = 0;
    wr(8'h20, 4'b1000, 32'hA5_00_00_00); exp.push_back(8'hA5);
    wr(8'h20, 4'b0111, 32'h11_22_33_44);
    for (int i = 0; i < 7; i++) begin
      wr(8'h20, 4'hF, {8'h11 + 8'(i), 24'h0});
      exp.push_back(8'h11 + 8'(i));
    end
    wr(8'h20, 4'b1000, 32'hEE00_0000);
    rd(8'h20, 4'hF, d); chk("R6 tx read zero", d, 0);
    chk("R7 tx_valid", {31'h0, tx_valid}, 1);
    repeat (3) @(negedge clk);
    chk("R7 hold head", {24'h0, tx_data}, 32'hA5);
    wr(8'h0C, 4'hF, 32'h0);
    rd(8'h0C, 4'hF, d); chk("R10 clear tx flag while busy", d, 0);
    tx_ready = 1;
    for (int i = 0; i < 10; i++) begin
      if (tx_valid) got.push_back(tx_data);
      @(negedge clk);
    end
    tx_ready = 0;
    chk("R6 tx count", got.size(), 8);
    for (int i = 0; i < 8 && i < got.size(); i++)
      chk("R7 tx order", {24'h0, got[i]}, {24'h0, exp[i]});
    rd(8'h0C, 4'hF, d); chk("R10 tx empty sets", d, 32'h0002_0000);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    wr(8'h08, 4'hF, 32'h0001_0000);
    chk("R11 no rx yet", {31'h0, irq}, 0);
    rx_feed(8'h30, 9);
    chk("R11 rx irq", {31'h0, irq}, 1);
    wr(8'h30, 4'hF, 32'hDEAD_BEEF);
    rd(8'h30, 4'b0111, d); chk("R9 low lanes no pop", d, 0);
    for (int i = 0; i < 8; i++) begin
      rd(8'h30, 4'b1000, d);
      chk("R8 rx data", d, {8'h30 + 8'(i), 24'h0});
    end
    rd(8'h30, 4'b1000, d); chk("R8 ninth dropped", d, 0);
    rd(8'h0C, 4'hF, d); chk("R10 rx sticky", d, 32'h0003_0000);
    wr(8'h0C, 4'hF, 32'h0);
    rd(8'h0C, 4'hF, d); chk("R10 clear rx flag", d, 32'h0002_0000);
    chk("R11 irq dropped", {31'h0, irq}, 0);
    wr(8'h08, 4'hF, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    rx_feed(8'h40, 3);
    wr(8'h20, 4'h8, 32'h5000_0000);
    wr(8'h20, 4'h8, 32'h5100_0000);
    wr(8'h10, 4'hF, 32'h0002_0000);
    rd(8'h30, 4'h8, d); chk("R12 no flush without enable", d, 32'h4000_0000);
    wr(8'h10, 4'hF, 32'h0006_0000);
    rd(8'h30, 4'h8, d); chk("R12 still no flush", d, 32'h4100_0000);
    wr(8'h10, 4'hF, 32'h0003_0000);
    rd(8'h30, 4'h8, d); chk("R12 rx flushed", d, 0);
    chk("R12 tx kept", {23'h0, tx_valid, tx_data}, 32'h150);
    wr(8'h10, 4'hF, 32'h0005_0000);
    chk("R12 tx flushed", {31'h0, tx_valid}, 0);
    rd(8'h10, 4'hF, d); chk("R12 fcr value", d, 32'h0005_0000);
    wr(8'h10, 4'hF, 32'h0);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    wr(8'h08, 4'hF, 32'h0008_0000);
    rd(8'h08, 4'hF, d); chk("R13 dma bit stored", d, 32'h0008_0000);
    chk("R13 no irq", {31'h0, irq}, 0);
    wr(8'h20, 4'h8, 32'h7700_0000);
    chk("R13 tx unaffected", {23'h0, tx_valid, tx_data}, 32'h177);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    chk("R7 single pop", {31'h0, tx_valid}, 0);
    wr(8'h08, 4'hF, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lanes_masks();
    t_unmapped();
    t_tx();
    t_rx();
    t_flush();
    t_dma();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule